// File: doc/BRIEF.md
# Delayed Transmit/Receive Switch with Masked Output Bank

This block decides when a radio front end should be in transmit and when in receive, and drives a 16-bit output bank from that decision. The request to transmit exists whenever transmit is enabled and the transmit sample queue holds data. The block does not pass this request straight through. The switch into transmit waits a programmable number of clock ticks, and so does the switch back to receive. Each wait can be set to match the latency of the transmit pipeline.

Each output pin follows the switch only if its mask bit is set. A masked pin shows its bit of a transmit pattern while the switch is in transmit, and its bit of a receive pattern otherwise. An unmasked pin shows a software-owned value. That value is written through a per-bit write mask, so software can change some pins without disturbing the others. All settings arrive over a simple strobe/address/data register bus.

Top module: `trx_switch_top`

## Requirements
- R1: The transmit request is high only while `tx_enable` is 1 and `fifo_empty` is 0. The indicator `tx_active` never rises while the request is low.
- R2: With a transmit delay of 0, `tx_active` goes high at the first clock edge that samples the request high.
- R3: With a transmit delay of D, `tx_active` goes high D edges after the edge at which it would rise with a delay of 0. While it waits, the internal count drops by one per edge.
- R4: With a receive delay of D, `tx_active` goes low D+1 edges after the request falls. A delay of 0 gives one edge.
- R5: If the request goes back to its earlier level before a wait ends, `tx_active` does not toggle.
- R6: When `auto_en` is 0, `tx_enable` is 0 or `txpath_rst_n` is 0 at an edge, `tx_active` is 0 after that edge, and the next switch into transmit starts from receive.
- R7: A write happens when `cfg_stb` is 1 at an edge. It goes to the register that `cfg_addr` selects: 2 is the transmit delay (32 bits), 3 the receive delay (32 bits), 4 the pin mask, 5 the transmit pattern and 6 the receive pattern. The last three take `cfg_data[15:0]`. A write to any other address leaves these registers unchanged.
- R8: A write to address 7 updates the software value as new = (old & ~cfg_data[31:16]) | (cfg_data[15:0] & cfg_data[31:16]).
- R9: Pin i shows the transmit-pattern bit when `auto_en` and mask bit i are both 1 and `tx_active` is 1. Under the same mask conditions with `tx_active` 0, it shows the receive-pattern bit. In every other case it shows software-value bit i.
- R10: After `rst_n` is low at an edge, every register is 0, so `gpio_out` and `tx_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| txpath_rst_n | input | 1 | Synchronous active-low reset of the switch timing only |
| cfg_stb | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address |
| cfg_data | input | 32 | Register write data |
| auto_en | input | 1 | Automatic switch control enable |
| tx_enable | input | 1 | Transmit path enable |
| fifo_empty | input | 1 | Transmit queue empty flag |
| tx_active | output | 1 | Delayed transmit indicator |
| gpio_out | output | 16 | Output pin bank |

## Verification
A wrong state or count appears on `tx_active` as an edge that comes too early or too late. It shows no later than the programmed delay plus one cycle after the request changes. The bench therefore measures the edge count of every transition against the delay, for several delays in each direction. A switch that fails to cancel leaves a stray pulse within the delay window. A wrong register or mask selection shows on `gpio_out` in the cycle after the write or after the indicator changes.

// File: rtl/trx_switch_pkg.sv
// Package: shared types and register addresses for the delayed
// transmit/receive switch. Assumes a 7-bit register address.
package trx_switch_pkg;
    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] A_TX_DLY = 7'd2;
    localparam logic [ADDR_W-1:0] A_RX_DLY = 7'd3;
    localparam logic [ADDR_W-1:0] A_MASK   = 7'd4;
    localparam logic [ADDR_W-1:0] A_TX_PAT = 7'd5;
    localparam logic [ADDR_W-1:0] A_RX_PAT = 7'd6;
    localparam logic [ADDR_W-1:0] A_SW_VAL = 7'd7;

    typedef enum logic [1:0] {
        ST_RX      = 2'd0,
        ST_WAIT_TX = 2'd1,
        ST_TX      = 2'd2,
        ST_WAIT_RX = 2'd3
    } sw_state_t;
endpackage

// File: rtl/trx_cfg_regs.sv
// Module: configuration register file. Holds both delays, the pin mask,
// the two patterns and the software value. Assumes the data bus is twice
// the pin-bank width so the software write can carry a per-bit mask.
module trx_cfg_regs
    import trx_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_stb,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic [CNT_W-1:0]  tx_dly,
    output logic [CNT_W-1:0]  rx_dly,
    output logic [IO_W-1:0]   pin_mask,
    output logic [IO_W-1:0]   tx_pat,
    output logic [IO_W-1:0]   rx_pat,
    output logic [IO_W-1:0]   sw_val
);
    localparam int MSK_LO = IO_W;

    logic [IO_W-1:0] wr_val, wr_msk;
    assign wr_val = cfg_data[IO_W-1:0];
    assign wr_msk = cfg_data[MSK_LO+IO_W-1:MSK_LO];

    // Purpose: decode strobed writes into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_dly   <= '0;
            rx_dly   <= '0;
            pin_mask <= '0;
            tx_pat   <= '0;
            rx_pat   <= '0;
            sw_val   <= '0;
        end else if (cfg_stb) begin
            case (cfg_addr)
                A_TX_DLY: tx_dly   <= cfg_data[CNT_W-1:0];
                A_RX_DLY: rx_dly   <= cfg_data[CNT_W-1:0];
                A_MASK:   pin_mask <= wr_val;
                A_TX_PAT: tx_pat   <= wr_val;
                A_RX_PAT: rx_pat   <= wr_val;
                A_SW_VAL: sw_val   <= (sw_val & ~wr_msk) | (wr_val & wr_msk);
                default:  ;
            endcase
        end
    end

    p_txdly_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stb && cfg_addr == A_TX_DLY) |=> tx_dly == $past(cfg_data[CNT_W-1:0]));
    p_other_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_stb && cfg_addr >= A_TX_DLY && cfg_addr <= A_RX_PAT)
        |=> ($stable(tx_dly) && $stable(rx_dly) && $stable(pin_mask)
             && $stable(tx_pat) && $stable(rx_pat)));
    p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_stb && cfg_addr == A_SW_VAL) |=> $stable(sw_val));
endmodule

// File: rtl/trx_delay_fsm.sv
// Module: four-state switch timer. Waits tx_dly edges before entering
// transmit and rx_dly edges before leaving it, and cancels a wait if the
// request returns to its earlier level. Assumes delays are stable while
// a wait is in progress.
module trx_delay_fsm
    import trx_switch_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             txpath_rst_n,
    input  logic             run,
    input  logic             req,
    input  logic [CNT_W-1:0] tx_dly,
    input  logic [CNT_W-1:0] rx_dly,
    output logic             tx_active
);
    sw_state_t        state;
    logic [CNT_W-1:0] cnt;

    // Purpose: advance the switch state and its wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !txpath_rst_n || !run) begin
            state <= ST_RX;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RX: if (req) begin
                    if (tx_dly == '0) state <= ST_TX;
                    else begin
                        state <= ST_WAIT_TX;
                        cnt   <= tx_dly - 1'b1;
                    end
                end
                ST_WAIT_TX: begin
                    if (!req)            state <= ST_RX;
                    else if (cnt == '0)  state <= ST_TX;
                    else                 cnt   <= cnt - 1'b1;
                end
                ST_TX: if (!req) begin
                    if (rx_dly == '0) state <= ST_RX;
                    else begin
                        state <= ST_WAIT_RX;
                        cnt   <= rx_dly - 1'b1;
                    end
                end
                default: begin
                    if (req)             state <= ST_TX;
                    else if (cnt == '0)  state <= ST_RX;
                    else                 cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign tx_active = (state == ST_TX) || (state == ST_WAIT_RX);

    p_rise_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(req));
    p_fall_needs_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_active) && $past(run) && $past(txpath_rst_n)) |-> !$past(req));
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_TX && run && txpath_rst_n && req && cnt != '0)
        |=> cnt == $past(cnt) - 1'b1);
    p_idle_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !txpath_rst_n) |=> !tx_active);
endmodule

// File: rtl/trx_pin_mux.sv
// Module: per-pin output selection between the transmit pattern, the
// receive pattern and the software value. Purely combinational.
module trx_pin_mux #(
    parameter int IO_W = 16
) (
    input  logic            auto_en,
    input  logic            tx_active,
    input  logic [IO_W-1:0] pin_mask,
    input  logic [IO_W-1:0] tx_pat,
    input  logic [IO_W-1:0] rx_pat,
    input  logic [IO_W-1:0] sw_val,
    output logic [IO_W-1:0] gpio_out
);
    for (genvar i = 0; i < IO_W; i++) begin : g_pin
        // Purpose: pick the source of pin i.
        always_comb begin
            if (auto_en && pin_mask[i])
                gpio_out[i] = tx_active ? tx_pat[i] : rx_pat[i];
            else
                gpio_out[i] = sw_val[i];
        end
    end
endmodule

// File: rtl/trx_switch_top.sv
// Module: top of the delayed transmit/receive switch. Forms the transmit
// request, times the switch, and drives the masked output bank.
// Assumes all inputs are synchronous to clk.
module trx_switch_top
    import trx_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IO_W   = 16,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txpath_rst_n,
    input  logic              cfg_stb,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              auto_en,
    input  logic              tx_enable,
    input  logic              fifo_empty,
    output logic              tx_active,
    output logic [IO_W-1:0]   gpio_out
);
    logic [CNT_W-1:0] tx_dly, rx_dly;
    logic [IO_W-1:0]  pin_mask, tx_pat, rx_pat, sw_val;
    logic             req, run;

    assign req = tx_enable && !fifo_empty;
    assign run = auto_en && tx_enable;

    trx_cfg_regs #(.DATA_W(DATA_W), .IO_W(IO_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_stb(cfg_stb), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .tx_dly(tx_dly), .rx_dly(rx_dly),
        .pin_mask(pin_mask), .tx_pat(tx_pat), .rx_pat(rx_pat), .sw_val(sw_val)
    );

    trx_delay_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .txpath_rst_n(txpath_rst_n), .run(run),
        .req(req), .tx_dly(tx_dly), .rx_dly(rx_dly), .tx_active(tx_active)
    );

    trx_pin_mux #(.IO_W(IO_W)) u_mux (
        .auto_en(auto_en), .tx_active(tx_active), .pin_mask(pin_mask),
        .tx_pat(tx_pat), .rx_pat(rx_pat), .sw_val(sw_val), .gpio_out(gpio_out)
    );

    p_manual_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> gpio_out == sw_val);
    p_no_tx_without_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> !tx_active);
endmodule

// File: tb/trx_switch_top_tb_top.sv
module trx_switch_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, txpath_rst_n = 1'b1;
    logic        cfg_stb = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        auto_en = 1'b0, tx_enable = 1'b0, fifo_empty = 1'b1;
    logic        tx_active;
    logic [15:0] gpio_out;

    int n_chk = 0, n_fail = 0;
    logic [15:0] m_mask = '0, m_tp = '0, m_rp = '0, m_sw = '0;

    always #5 clk = ~clk;

    trx_switch_top dut_i (
        .clk(clk), .rst_n(rst_n), .txpath_rst_n(txpath_rst_n),
        .cfg_stb(cfg_stb), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .auto_en(auto_en), .tx_enable(tx_enable), .fifo_empty(fifo_empty),
        .tx_active(tx_active), .gpio_out(gpio_out)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        cfg_stb = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_stb = 1'b0;
    endtask

    function automatic logic [15:0] exp_pins(input logic ae, input logic ind);
        logic [15:0] sel = ae ? m_mask : 16'h0;
        return (sel & (ind ? m_tp : m_rp)) | (~sel & m_sw);
    endfunction

    // Edges until tx_active reaches lvl, capped at 40.
    task automatic edges_to(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (tx_active != lvl && n < 40);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check("R10 reset tx_active", tx_active, 0);
        check("R10 reset gpio", gpio_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: masked software writes
        foreach (m_sw[k]) begin
            logic [15:0] v = 16'hA5C3 ^ (16'h1 << k) ^ 16'(k * 16'h0F0F);
            logic [15:0] m = 16'hFFFF >> k;
            wr(7'd7, {m, v});
            m_sw = (m_sw & ~m) | (v & m);
            check("R8 sw masked write", gpio_out, m_sw);
        end

        // R7: pattern registers and ignored addresses
        m_mask = 16'h0FF0; m_tp = 16'h3C3C; m_rp = 16'hC3A5;
        wr(7'd4, {16'hFFFF, m_mask});
        wr(7'd5, {16'hFFFF, m_tp});
        wr(7'd6, {16'hFFFF, m_rp});
        auto_en = 1'b1; @(negedge clk);
        check("R7 R9 rx pattern on masked pins", gpio_out, exp_pins(1'b1, 1'b0));
        for (int a = 8; a < 128; a += 17) wr(7'(a), 32'hFFFF_FFFF);
        wr(7'd0, 32'hFFFF_FFFF); wr(7'd1, 32'hFFFF_FFFF);
        check("R7 unmapped writes ignored", gpio_out, exp_pins(1'b1, 1'b0));

        // R1: request needs tx_enable
        tx_enable = 1'b0; fifo_empty = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 no tx without enable", tx_active, 0);
        tx_enable = 1'b1; fifo_empty = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 no tx with empty fifo", tx_active, 0);

        // R2 R3 R4: delay sweep
        for (int dt = 0; dt < 6; dt++) begin
            for (int dr = 0; dr < 6; dr++) begin
                wr(7'd2, 32'(dt)); wr(7'd3, 32'(dr));
                fifo_empty = 1'b0;
                edges_to(1'b1, n);
                check(dt == 0 ? "R2 zero tx delay" : "R3 tx delay", n, dt + 1);
                check("R9 tx pattern", gpio_out, exp_pins(1'b1, 1'b1));
                fifo_empty = 1'b1;
                edges_to(1'b0, n);
                check("R4 rx delay", n, dr + 1);
                check("R9 rx pattern", gpio_out, exp_pins(1'b1, 1'b0));
            end
        end

        // R5: cancelled waits
        wr(7'd2, 32'd4); wr(7'd3, 32'd4);
        fifo_empty = 1'b0; repeat (3) @(negedge clk); fifo_empty = 1'b1;
        n = 0;
        for (int c = 0; c < 10; c++) begin @(negedge clk); n += tx_active; end
        check("R5 cancelled tx wait no pulse", n, 0);
        fifo_empty = 1'b0; edges_to(1'b1, n);
        check("R5 clean entry after cancel", n, 5);
        fifo_empty = 1'b1; repeat (3) @(negedge clk); fifo_empty = 1'b0;
        n = 0;
        for (int c = 0; c < 10; c++) begin @(negedge clk); n += !tx_active; end
        check("R5 cancelled rx wait no drop", n, 0);

        // R6: disable and path reset force receive
        auto_en = 1'b0; @(negedge clk);
        check("R6 auto off forces rx", tx_active, 0);
        check("R9 manual pins", gpio_out, exp_pins(1'b0, 1'b0));
        auto_en = 1'b1; edges_to(1'b1, n);
        check("R6 restart from rx", n, 5);
        txpath_rst_n = 1'b0; @(negedge clk);
        check("R6 path reset forces rx", tx_active, 0);
        txpath_rst_n = 1'b1; edges_to(1'b1, n);
        check("R6 restart after path reset", n, 5);
        tx_enable = 1'b0; @(negedge clk);
        check("R6 tx_enable off forces rx", tx_active, 0);

        // R10: full reset clears registers
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; auto_en = 1'b0;
        @(negedge clk);
        check("R10 gpio after reset", gpio_out, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule